// File: doc/BRIEF.md
# ECC Error Logger with Threshold Interrupt

This block sits after an ECC checker on a memory read path. Each read can report one of two error events: a corrected single-bit error or an uncorrectable error. The block keeps the status that software needs to service those events. For every single-bit error it records the read address and the details of the error. It counts single-bit errors against a programmable threshold. For uncorrectable errors it records the address.

The block has two interrupt outputs. The single-error interrupt fires on the first corrected error that arrives once the counter has already reached the threshold. The uncorrectable interrupt fires on an uncorrectable error. Each interrupt has a sticky flag, and each output is a one-cycle pulse that is produced only when its flag goes from 0 to 1. An interrupt therefore stays silent until software releases its flag through the interrupt-clear register.

The register port is a plain word interface. A write takes effect on the clock edge on which `reg_wr` is high. A read returns combinationally the register selected by `reg_addr`. A global enable bit freezes all logging when it is cleared.

Top module: `ecc_err_logger`

Register indices:
- 0: control, with bit 0 the enable.
- 1: threshold.
- 2: error count.
- 3: single-error address.
- 4: uncorrectable address.
- 5: diagnostic.
- 6: status.
- 7: interrupt flags.
- 8: interrupt clear.

## Requirements
- R1: After reset every register reads zero, except control, which reads 1 (logging enabled). Both interrupt outputs are low.
- R2: While control bit 0 is 0, error events change neither the count, the captured addresses, the diagnostic, the status nor the interrupt flags, and they raise no interrupt.
- R3: On an enabled single-bit error, register 3 takes the read address. Register 5 takes the bit position in bits [POS_W-1:0], the check-bit indicator in bit 8 and the upper-half indicator in bit 9. Status bit 0 (corrected to 0) or status bit 1 (corrected to 1) is set according to `evt_fix_one`.
- R4: Each enabled single-bit error increments the count while the count is below the threshold. Once the count is at or above the threshold, the count holds.
- R5: A single-bit error that arrives while the count is at or above the threshold sets interrupt-flag bit 0. If that bit was clear, `irq_single` is high for exactly the one cycle that follows the event.
- R6: While interrupt-flag bit 0 is set, further qualifying errors raise no pulse. Writing 1 to bit 0 of register 8 clears the flag, and the next qualifying error fires again.
- R7: An enabled uncorrectable error loads register 4 with the address and sets status bit 2 and interrupt-flag bit 1. If flag bit 1 was clear, it also pulses `irq_unc` for one cycle. No further pulse is raised until bit 1 of register 8 is written with 1.
- R8: When an interrupt-clear write and a new qualifying error fall in the same cycle, the flag stays set and no pulse is raised.
- R9: Any write to register 2 resets the count to zero. Writing 1 to status bits 0..2 clears them. Writing 1 to status bit 3 zeroes registers 3, 4 and 5.
- R10: The threshold register holds CNT_W bits and reads back its low CNT_W bits, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_single | input | 1 | Corrected single-bit error on this read |
| evt_unc | input | 1 | Uncorrectable error on this read |
| evt_addr | input | ADDR_W | Address of the read |
| evt_bit_pos | input | POS_W | Position of the flipped bit |
| evt_in_check | input | 1 | Flipped bit lies in the check bits |
| evt_upper | input | 1 | Error lies in the upper half of the wide word |
| evt_fix_one | input | 1 | Corrected value of the bit is 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| irq_single | output | 1 | Single-error threshold interrupt pulse |
| irq_unc | output | 1 | Uncorrectable error interrupt pulse |

## Verification
A corrupt counter shows up at the ports as a threshold interrupt on the wrong error of a run. The bench sweeps several thresholds and reads the count after every event, so a bad count is visible at once. A sticky flag held in the wrong state shows as a missing pulse or a repeated pulse on the event right after the fault, and the bench compares the interrupt outputs on every event. A wrong capture or a wrong field position appears on the next register read. The bench reads the captured fields after every event of a full sweep of bit positions.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      RG_CTRL   = 4'd0,
      RG_THRESH = 4'd1,
      RG_COUNT  = 4'd2,
      RG_SADDR  = 4'd3,
      RG_UADDR  = 4'd4,
      RG_DIAG   = 4'd5,
      RG_STATUS = 4'd6,
      RG_IFLAG  = 4'd7,
      RG_ICLR   = 4'd8
   } reg_sel_e;

   // diagnostic field positions
   localparam int DG_CHK_BIT = 8;
   localparam int DG_UP_BIT  = 9;
   // status bit positions
   localparam int ST_FIX0 = 0;
   localparam int ST_FIX1 = 1;
   localparam int ST_UNC  = 2;
   localparam int ST_WIPE = 3;
   // interrupt channels
   localparam int IRQ_N   = 2;
   localparam int IRQ_SGL = 0;
   localparam int IRQ_UNC = 1;
endpackage

// File: rtl/ecc_log_counter.sv
module ecc_log_counter #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             zero,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             reached
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign reached = (count >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (zero)           count <= '0;
      else if (hit && !reached) count <= count + ONE;
   end
endmodule

// File: rtl/ecc_log_sticky.sv
module ecc_log_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag,
   output logic pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         pulse <= 1'b0;
      end else begin
         flag  <= set | (flag & ~clr);
         pulse <= set & ~flag;
      end
   end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         wipe,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
      else if (wipe) q <= '0;
   end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger import ecc_log_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int POS_W  = 7,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_single,
   input  logic              evt_unc,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [POS_W-1:0]  evt_bit_pos,
   input  logic              evt_in_check,
   input  logic              evt_upper,
   input  logic              evt_fix_one,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_single,
   output logic              irq_unc
);
   localparam int DIAG_W = POS_W + 2;

   if (ADDR_W > DATA_W) begin : g_chk_addr
      $error("ADDR_W must not exceed DATA_W");
   end
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("CNT_W must not exceed DATA_W");
   end
   if (POS_W > DG_CHK_BIT || POS_W < 1) begin : g_chk_pos
      $error("POS_W must lie in 1..8");
   end

   logic             en_q;
   logic [CNT_W-1:0] thr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_lim;
   logic [2:0]       st_q;
   logic [2:0]       st_set;
   logic [2:0]       st_clr;
   logic             hit_s, hit_u;
   logic             wr_ctrl, wr_thr, wr_cnt, wr_stat, wr_iclr, wipe;
   logic [ADDR_W-1:0] saddr_q, uaddr_q;
   logic [DIAG_W-1:0] diag_q;
   logic [IRQ_N-1:0]  irq_set, irq_clr, irq_flag, irq_pls;

   assign hit_s = en_q & evt_single;
   assign hit_u = en_q & evt_unc;

   assign wr_ctrl = reg_wr && (reg_addr == RG_CTRL);
   assign wr_thr  = reg_wr && (reg_addr == RG_THRESH);
   assign wr_cnt  = reg_wr && (reg_addr == RG_COUNT);
   assign wr_stat = reg_wr && (reg_addr == RG_STATUS);
   assign wr_iclr = reg_wr && (reg_addr == RG_ICLR);
   assign wipe    = wr_stat & reg_wdata[ST_WIPE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b1;
         thr_q <= '0;
      end else begin
         if (wr_ctrl) en_q  <= reg_wdata[0];
         if (wr_thr)  thr_q <= reg_wdata[CNT_W-1:0];
      end
   end

   ecc_log_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(hit_s), .zero(wr_cnt),
      .limit(thr_q), .count(cnt_q), .reached(at_lim)
   );

   // status bits: new event outranks a clear in the same cycle
   assign st_set[ST_FIX0] = hit_s & ~evt_fix_one;
   assign st_set[ST_FIX1] = hit_s &  evt_fix_one;
   assign st_set[ST_UNC]  = hit_u;
   assign st_clr          = {3{wr_stat}} & reg_wdata[2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_set | (st_q & ~st_clr);
   end

   ecc_log_capture #(.W(ADDR_W)) u_saddr (
      .clk(clk), .rst_n(rst_n), .load(hit_s), .wipe(wipe),
      .din(evt_addr), .q(saddr_q)
   );
   ecc_log_capture #(.W(ADDR_W)) u_uaddr (
      .clk(clk), .rst_n(rst_n), .load(hit_u), .wipe(wipe),
      .din(evt_addr), .q(uaddr_q)
   );
   ecc_log_capture #(.W(DIAG_W)) u_diag (
      .clk(clk), .rst_n(rst_n), .load(hit_s), .wipe(wipe),
      .din({evt_upper, evt_in_check, evt_bit_pos}), .q(diag_q)
   );

   assign irq_set[IRQ_SGL] = hit_s & at_lim;
   assign irq_set[IRQ_UNC] = hit_u;
   assign irq_clr          = {IRQ_N{wr_iclr}} & reg_wdata[IRQ_N-1:0];

   for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
      ecc_log_sticky u_stk (
         .clk(clk), .rst_n(rst_n), .set(irq_set[g]), .clr(irq_clr[g]),
         .flag(irq_flag[g]), .pulse(irq_pls[g])
      );
   end

   assign irq_single = irq_pls[IRQ_SGL];
   assign irq_unc    = irq_pls[IRQ_UNC];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RG_CTRL:   reg_rdata[0] = en_q;
         RG_THRESH: reg_rdata = DATA_W'(thr_q);
         RG_COUNT:  reg_rdata = DATA_W'(cnt_q);
         RG_SADDR:  reg_rdata = DATA_W'(saddr_q);
         RG_UADDR:  reg_rdata = DATA_W'(uaddr_q);
         RG_DIAG: begin
            reg_rdata[POS_W-1:0]  = diag_q[POS_W-1:0];
            reg_rdata[DG_CHK_BIT] = diag_q[POS_W];
            reg_rdata[DG_UP_BIT]  = diag_q[POS_W+1];
         end
         RG_STATUS: reg_rdata[2:0] = st_q;
         RG_IFLAG:  reg_rdata[IRQ_N-1:0] = irq_flag;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             evt_single,
   input logic             evt_unc,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] thr,
   input logic             cnt_wr,
   input logic             flag_s,
   input logic             flag_u,
   input logic             irq_s,
   input logic             irq_u
);
   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_wr) |=> cnt == $past(cnt));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt_single && cnt < thr && !cnt_wr) |=> cnt == $past(cnt) + CNT_W'(1));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= thr && !cnt_wr) |=> cnt == $past(cnt));

   p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_s |=> !irq_s);

   p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_s |-> (flag_s && !$past(flag_s)));

   p_unc_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt_unc && !flag_u) |=> (irq_u && flag_u));

   p_unc_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_u |-> !$past(flag_u));

   p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt_single && cnt >= thr) |=> flag_s);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_q), .evt_single(evt_single),
   .evt_unc(evt_unc), .cnt(cnt_q), .thr(thr_q), .cnt_wr(wr_cnt),
   .flag_s(irq_flag[0]), .flag_u(irq_flag[1]),
   .irq_s(irq_single), .irq_u(irq_unc)
);

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_CTRL = 0, A_THR = 1, A_CNT = 2, A_SADDR = 3,
                          A_UADDR = 4, A_DIAG = 5, A_STAT = 6, A_IFLAG = 7,
                          A_ICLR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_single = 0, evt_unc = 0, evt_in_check = 0, evt_upper = 0, evt_fix_one = 0;
   logic [31:0] evt_addr = '0;
   logic [6:0]  evt_bit_pos = '0;
   logic        reg_wr = 0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_single, irq_unc;

   int n_chk = 0;
   int n_bad = 0;

   ecc_err_logger dut_i (
      .clk(clk), .rst_n(rst_n), .evt_single(evt_single), .evt_unc(evt_unc),
      .evt_addr(evt_addr), .evt_bit_pos(evt_bit_pos), .evt_in_check(evt_in_check),
      .evt_upper(evt_upper), .evt_fix_one(evt_fix_one), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_single(irq_single), .irq_unc(irq_unc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   // one event cycle; returns the interrupt outputs seen in the following cycle
   task automatic ev(input bit s, input bit u, input logic [31:0] a, input int pos,
                     input bit c, input bit up, input bit one,
                     output bit is, output bit iu);
      @(negedge clk);
      evt_single = s; evt_unc = u; evt_addr = a; evt_bit_pos = 7'(pos);
      evt_in_check = c; evt_upper = up; evt_fix_one = one;
      @(negedge clk);
      is = irq_single; iu = irq_unc;
      evt_single = 0; evt_unc = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      bit is, iu;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      check("R1 irq_single", 32'(irq_single), 0);
      check("R1 irq_unc", 32'(irq_unc), 0);
      rd_chk("R1 ctrl", A_CTRL, 1);
      rd_chk("R1 thresh", A_THR, 0);
      rd_chk("R1 count", A_CNT, 0);
      rd_chk("R1 saddr", A_SADDR, 0);
      rd_chk("R1 uaddr", A_UADDR, 0);
      rd_chk("R1 diag", A_DIAG, 0);
      rd_chk("R1 status", A_STAT, 0);
      rd_chk("R1 iflag", A_IFLAG, 0);

      // R10 threshold width
      wr(A_THR, 32'hFFFF_ABCD);
      rd_chk("R10 thresh readback", A_THR, 32'h0000_ABCD);

      // R2 logging disabled
      wr(A_CTRL, 0);
      rd_chk("R2 ctrl", A_CTRL, 0);
      ev(1, 0, 32'h1234, 5, 1, 1, 1, is, iu);
      check("R2 no irq_single", 32'(is), 0);
      ev(0, 1, 32'h5678, 0, 0, 0, 0, is, iu);
      check("R2 no irq_unc", 32'(iu), 0);
      rd_chk("R2 count", A_CNT, 0);
      rd_chk("R2 saddr", A_SADDR, 0);
      rd_chk("R2 uaddr", A_UADDR, 0);
      rd_chk("R2 diag", A_DIAG, 0);
      rd_chk("R2 status", A_STAT, 0);
      rd_chk("R2 iflag", A_IFLAG, 0);
      wr(A_CTRL, 1);

      // R4 R5 R6 threshold sweep
      for (int t = 0; t <= 6; t++) begin
         wr(A_THR, 32'(t));
         wr(A_CNT, 0);
         wr(A_ICLR, 1);
         for (int i = 1; i <= t + 3; i++) begin
            ev(1, 0, 32'(i), 0, 0, 0, 0, is, iu);
            check($sformatf("R5 irq t=%0d i=%0d", t, i), 32'(is), 32'(i == t + 1));
            rd_chk($sformatf("R4 count t=%0d i=%0d", t, i), A_CNT, 32'((i < t) ? i : t));
            rd_chk($sformatf("R6 flag t=%0d i=%0d", t, i), A_IFLAG, 32'(i > t));
         end
         wr(A_ICLR, 1);
         rd_chk($sformatf("R6 cleared t=%0d", t), A_IFLAG, 0);
         ev(1, 0, 32'h99, 0, 0, 0, 0, is, iu);
         check($sformatf("R6 refire t=%0d", t), 32'(is), 1);
      end

      // R3 capture sweep over all bit positions
      for (int p = 0; p < 128; p++) begin
         logic [31:0] a;
         bit c, up, one;
         a = (32'(p) * 32'h0101_0101) ^ 32'h5A5A_0000;
         c = p[0]; up = p[1]; one = p[2];
         wr(A_STAT, 3);
         ev(1, 0, a, p, c, up, one, is, iu);
         rd_chk($sformatf("R3 saddr p=%0d", p), A_SADDR, a);
         rd_chk($sformatf("R3 diag p=%0d", p), A_DIAG,
                32'(p) | (32'(c) << 8) | (32'(up) << 9));
         rd_chk($sformatf("R3 status p=%0d", p), A_STAT, one ? 32'd2 : 32'd1);
      end

      // R7 uncorrectable path
      wr(A_ICLR, 3);
      wr(A_STAT, 7);
      ev(0, 1, 32'hCAFE_0010, 0, 0, 0, 0, is, iu);
      check("R7 first irq_unc", 32'(iu), 1);
      rd_chk("R7 uaddr", A_UADDR, 32'hCAFE_0010);
      rd_chk("R7 status", A_STAT, 4);
      rd_chk("R7 iflag", A_IFLAG, 2);
      ev(0, 1, 32'hCAFE_0020, 0, 0, 0, 0, is, iu);
      check("R7 no refire", 32'(iu), 0);
      rd_chk("R7 uaddr update", A_UADDR, 32'hCAFE_0020);
      wr(A_ICLR, 2);
      rd_chk("R7 flag cleared", A_IFLAG, 0);
      ev(0, 1, 32'hCAFE_0030, 0, 0, 0, 0, is, iu);
      check("R7 fires after clear", 32'(iu), 1);

      // R8 clear write colliding with new errors
      wr(A_THR, 0);
      wr(A_ICLR, 1);
      ev(1, 0, 32'h10, 0, 0, 0, 0, is, iu);
      check("R8 setup pulse", 32'(is), 1);
      @(negedge clk);
      reg_wr = 1; reg_addr = A_ICLR; reg_wdata = 3;
      evt_single = 1; evt_unc = 1;
      @(negedge clk);
      check("R8 no single pulse", 32'(irq_single), 0);
      check("R8 no unc pulse", 32'(irq_unc), 0);
      reg_wr = 0; evt_single = 0; evt_unc = 0;
      rd_chk("R8 flags kept", A_IFLAG, 3);

      // R9 count reset and status clears
      wr(A_THR, 10);
      wr(A_CNT, 0);
      repeat (3) ev(1, 0, 32'h20, 3, 0, 0, 0, is, iu);
      rd_chk("R9 count before", A_CNT, 3);
      wr(A_CNT, 32'hFFFF);
      rd_chk("R9 count zeroed", A_CNT, 0);
      wr(A_STAT, 32'hF);
      rd_chk("R9 status", A_STAT, 0);
      rd_chk("R9 saddr", A_SADDR, 0);
      rd_chk("R9 uaddr", A_UADDR, 0);
      rd_chk("R9 diag", A_DIAG, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule